// File: doc/BRIEF.md
# Belt Operand Store with Rescue

This block holds the operands of a statically scheduled machine as a belt: a fixed-length queue of eight positions addressed by age. Every result enters at the front as position 0 and pushes each older value one position further back; a value pushed past the last position can no longer be read. Up to two results enter per cycle, one per issuing slot. Up to four read ports name positions and receive the stored value. A value brought back from scratch storage is handed in as an ordinary drop.

Positions do not hold data themselves. Each one carries a valid bit and an index into a sixteen-entry physical value array. A drop takes an entry that no valid position references and writes its data there. The rescue command takes an ordered list of positions and rebuilds the front of the belt from them. Every position that is not named is dropped. Rescue rewrites only the position-to-entry map and never copies data.

Top module: `belt_operand_store`

## Requirements
- R1: After reset every position is invalid, so an enabled read of any position returns zero with its error flag set.
- R2: A single drop from either slot becomes position 0 on the next cycle, and every older value moves one position back.
- R3: When both slots drop in one cycle, the slot 1 value becomes position 0 and the slot 0 value becomes position 1. Every older value moves two positions back.
- R4: A value shifted beyond position 7 is lost. Position 7 always holds the eighth most recent value.
- R5: Reads are combinational and show the belt as it stood before the current cycle's drops or rescue. A value dropped in cycle N is first readable in cycle N+1.
- R6: A rescue with count C and list entries L[0]..L[C-1] makes the value formerly at L[k] the new position C-1-k. Positions C and above become invalid.
- R7: Rescue leaves stored values unchanged. A position may appear more than once in the list, and each copy reads the same value.
- R8: When a rescue and drops arrive in the same cycle, the rescue is applied first and the drops then land in front of the rescued belt.
- R9: An enabled read of an invalid position returns zero with its error flag set. A disabled read port returns zero with no error.
- R10: Each drop is written to a physical entry that no valid position references. Live values are therefore never overwritten, whatever mix of drops and rescues occurs.
- R11: A rescue count of 0 empties the belt. A count above 8 behaves as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drop_en | input | 2 | Drop request per slot (bit 0 = slot 0) |
| drop_data | input | 2x32 | Drop value per slot |
| rescue_en | input | 1 | Apply a rescue this cycle |
| rescue_cnt | input | 4 | Number of list entries used |
| rescue_list | input | 8x3 | Ordered list of positions; entry k is element k |
| rd_en | input | 4 | Read enable per port |
| rd_pos | input | 4x3 | Position read by each port |
| rd_data | output | 4x32 | Value read, zero when invalid or disabled |
| rd_err | output | 4 | Enabled read of an invalid position |

## Verification
Read results arrive with no delay: they depend only on the registered map and the array, so the bench drives inputs on the falling edge and compares all four ports a short time later in that same cycle. A drop or rescue lands on the next rising edge. The reference model in the bench is therefore updated after each comparison and checked against the ports one cycle after the stimulus. Sweeps of all eight positions over two idle cycles show the complete belt after each directed step. Clocked properties check the map one edge after each command.

// File: rtl/belt_pkg.sv
`timescale 1ns/1ps
// Package: default geometry shared by the belt operand store and its checker.
// Assumes at least two belt positions and at least belt length + 2 physical entries.
package belt_pkg;
    localparam int BELT_POSITIONS = 8;
    localparam int PHYS_ENTRIES   = 16;
    localparam int VALUE_WIDTH    = 32;
    localparam int READ_PORTS     = 4;
    localparam int DROP_SLOTS     = 2;
endpackage

// File: rtl/belt_free_alloc.sv
`timescale 1ns/1ps
// Module: picks two distinct free physical entries from a free mask.
// Assumes the mask has at least two bits set (guaranteed when entries exceed positions + 1).
module belt_free_alloc #(
    parameter int NPHYS = belt_pkg::PHYS_ENTRIES,
    localparam int PW   = $clog2(NPHYS)
) (
    input  logic [NPHYS-1:0] free_mask,
    output logic [PW-1:0]    pick0,
    output logic [PW-1:0]    pick1
);
    logic [NPHYS-1:0] rest_mask;
    logic             got0;
    logic             got1;

    // Lowest free entry, then lowest free entry other than the first.
    always_comb begin
        pick0 = '0;
        got0  = 1'b0;
        for (int i = 0; i < NPHYS; i++) begin
            if (free_mask[i] && !got0) begin
                pick0 = PW'(i);
                got0  = 1'b1;
            end
        end
        rest_mask        = free_mask;
        rest_mask[pick0] = 1'b0;
        pick1 = '0;
        got1  = 1'b0;
        for (int i = 0; i < NPHYS; i++) begin
            if (rest_mask[i] && !got1) begin
                pick1 = PW'(i);
                got1  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/belt_map.sv
`timescale 1ns/1ps
// Module: position-to-entry map with per-position valid bits.
// Applies rescue first, then shifts in zero, one or two drops (slot 1 newest).
// Assumes alloc0/alloc1 are distinct and unreferenced.
module belt_map #(
    parameter int NPOS  = belt_pkg::BELT_POSITIONS,
    parameter int NPHYS = belt_pkg::PHYS_ENTRIES,
    localparam int PW   = $clog2(NPHYS),
    localparam int LW   = $clog2(NPOS),
    localparam int CW   = $clog2(NPOS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               drop_en,
    input  logic [PW-1:0]            alloc0,
    input  logic [PW-1:0]            alloc1,
    input  logic                     rescue_en,
    input  logic [CW-1:0]            rescue_cnt,
    input  logic [NPOS-1:0][LW-1:0]  rescue_list,
    output logic [NPOS-1:0][PW-1:0]  map_q,
    output logic [NPOS-1:0]          vld_q
);
    logic [NPOS-1:0][PW-1:0] m_resc;
    logic [NPOS-1:0]         v_resc;
    logic [NPOS-1:0][PW-1:0] m_next;
    logic [NPOS-1:0]         v_next;
    logic [LW-1:0]           src;
    int                      cnt_eff;

    // Stage 1: rebuild the front from the rescue list (last entry becomes position 0).
    always_comb begin
        cnt_eff = (int'(rescue_cnt) > NPOS) ? NPOS : int'(rescue_cnt);
        m_resc  = map_q;
        v_resc  = vld_q;
        src     = '0;
        if (rescue_en) begin
            for (int j = 0; j < NPOS; j++) begin
                if (j < cnt_eff) begin
                    src       = rescue_list[LW'(cnt_eff - 1 - j)];
                    m_resc[j] = map_q[src];
                    v_resc[j] = vld_q[src];
                end else begin
                    m_resc[j] = '0;
                    v_resc[j] = 1'b0;
                end
            end
        end
    end

    // Stage 2: drops land in front of the (possibly rescued) belt.
    always_comb begin
        m_next = m_resc;
        v_next = v_resc;
        unique case (drop_en)
            2'b01, 2'b10: begin
                for (int j = 1; j < NPOS; j++) begin
                    m_next[j] = m_resc[j-1];
                    v_next[j] = v_resc[j-1];
                end
                m_next[0] = drop_en[0] ? alloc0 : alloc1;
                v_next[0] = 1'b1;
            end
            2'b11: begin
                for (int j = 2; j < NPOS; j++) begin
                    m_next[j] = m_resc[j-2];
                    v_next[j] = v_resc[j-2];
                end
                m_next[1] = alloc0;
                m_next[0] = alloc1;
                v_next[1] = 1'b1;
                v_next[0] = 1'b1;
            end
            default: ;
        endcase
    end

    // Register the map; reset leaves every position invalid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
            vld_q <= '0;
        end else begin
            map_q <= m_next;
            vld_q <= v_next;
        end
    end
endmodule

// File: rtl/belt_phys_store.sv
`timescale 1ns/1ps
// Module: physical value array with two write ports and mapped read ports.
// Assumes write addresses differ when both writes are enabled.
module belt_phys_store #(
    parameter int NPOS  = belt_pkg::BELT_POSITIONS,
    parameter int NPHYS = belt_pkg::PHYS_ENTRIES,
    parameter int W     = belt_pkg::VALUE_WIDTH,
    parameter int NRD   = belt_pkg::READ_PORTS,
    localparam int PW   = $clog2(NPHYS),
    localparam int LW   = $clog2(NPOS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               we,
    input  logic [PW-1:0]            waddr0,
    input  logic [PW-1:0]            waddr1,
    input  logic [1:0][W-1:0]        wdata,
    input  logic [NPOS-1:0][PW-1:0]  map_q,
    input  logic [NPOS-1:0]          vld_q,
    input  logic [NRD-1:0]           rd_en,
    input  logic [NRD-1:0][LW-1:0]   rd_pos,
    output logic [NRD-1:0][W-1:0]    rd_data,
    output logic [NRD-1:0]           rd_err
);
    logic [W-1:0] mem [NPHYS];

    // Write dropped values into their allocated entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
        end else begin
            if (we[0]) mem[waddr0] <= wdata[0];
            if (we[1]) mem[waddr1] <= wdata[1];
        end
    end

    // Translate each read position through the map; flag invalid positions.
    always_comb begin
        for (int g = 0; g < NRD; g++) begin
            rd_data[g] = '0;
            rd_err[g]  = 1'b0;
            if (rd_en[g]) begin
                if (vld_q[rd_pos[g]]) rd_data[g] = mem[map_q[rd_pos[g]]];
                else                  rd_err[g]  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/belt_operand_store.sv
`timescale 1ns/1ps
// Module: top of the belt operand store. Two drop slots, rescue by renaming,
// combinational reads of the pre-update belt.
// Assumes NPHYS >= NPOS + 2 so two free entries always exist.
module belt_operand_store #(
    parameter int NPOS  = belt_pkg::BELT_POSITIONS,
    parameter int NPHYS = belt_pkg::PHYS_ENTRIES,
    parameter int W     = belt_pkg::VALUE_WIDTH,
    parameter int NRD   = belt_pkg::READ_PORTS,
    localparam int PW   = $clog2(NPHYS),
    localparam int LW   = $clog2(NPOS),
    localparam int CW   = $clog2(NPOS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               drop_en,
    input  logic [1:0][W-1:0]        drop_data,
    input  logic                     rescue_en,
    input  logic [CW-1:0]            rescue_cnt,
    input  logic [NPOS-1:0][LW-1:0]  rescue_list,
    input  logic [NRD-1:0]           rd_en,
    input  logic [NRD-1:0][LW-1:0]   rd_pos,
    output logic [NRD-1:0][W-1:0]    rd_data,
    output logic [NRD-1:0]           rd_err
);
    logic [NPOS-1:0][PW-1:0] map_q;
    logic [NPOS-1:0]         vld_q;
    logic [NPHYS-1:0]        free_mask;
    logic [PW-1:0]           alloc0;
    logic [PW-1:0]           alloc1;

    // Free list: entries referenced by no valid position.
    always_comb begin
        free_mask = '1;
        for (int p = 0; p < NPOS; p++) begin
            if (vld_q[p]) free_mask[map_q[p]] = 1'b0;
        end
    end

    belt_free_alloc #(.NPHYS(NPHYS)) u_alloc (
        .free_mask (free_mask),
        .pick0     (alloc0),
        .pick1     (alloc1)
    );

    belt_map #(.NPOS(NPOS), .NPHYS(NPHYS)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .drop_en     (drop_en),
        .alloc0      (alloc0),
        .alloc1      (alloc1),
        .rescue_en   (rescue_en),
        .rescue_cnt  (rescue_cnt),
        .rescue_list (rescue_list),
        .map_q       (map_q),
        .vld_q       (vld_q)
    );

    belt_phys_store #(.NPOS(NPOS), .NPHYS(NPHYS), .W(W), .NRD(NRD)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (drop_en),
        .waddr0  (alloc0),
        .waddr1  (alloc1),
        .wdata   (drop_data),
        .map_q   (map_q),
        .vld_q   (vld_q),
        .rd_en   (rd_en),
        .rd_pos  (rd_pos),
        .rd_data (rd_data),
        .rd_err  (rd_err)
    );
endmodule

// File: rtl/belt_operand_store_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the map, allocator and read flags.
// Assumes it is bound into belt_operand_store.
module belt_operand_store_chk #(
    parameter int NPOS  = belt_pkg::BELT_POSITIONS,
    parameter int NPHYS = belt_pkg::PHYS_ENTRIES,
    parameter int NRD   = belt_pkg::READ_PORTS,
    localparam int PW   = $clog2(NPHYS),
    localparam int LW   = $clog2(NPOS),
    localparam int CW   = $clog2(NPOS + 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               drop_en,
    input logic                     rescue_en,
    input logic [CW-1:0]            rescue_cnt,
    input logic [NPOS-1:0][LW-1:0]  rescue_list,
    input logic [NRD-1:0]           rd_en,
    input logic [NRD-1:0]           rd_err,
    input logic [NPOS-1:0][PW-1:0]  map_q,
    input logic [NPOS-1:0]          vld_q,
    input logic [NPHYS-1:0]         free_mask,
    input logic [PW-1:0]            alloc0,
    input logic [PW-1:0]            alloc1
);
    logic [LW-1:0] last_idx;
    logic [PW-1:0] head_ent;
    logic          head_vld;

    // Entry expected at position 0 after a rescue without drops.
    always_comb begin
        last_idx = (int'(rescue_cnt) >= NPOS) ? LW'(NPOS - 1) : LW'(int'(rescue_cnt) - 1);
        head_ent = map_q[rescue_list[last_idx]];
        head_vld = vld_q[rescue_list[last_idx]];
    end

    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (vld_q == '0));

    assert_single_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_en == 2'b01 && !rescue_en) |=>
            (vld_q[0] && map_q[1] == $past(map_q[0]) && vld_q[1] == $past(vld_q[0])));

    assert_dual_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_en == 2'b11 && !rescue_en) |=>
            (map_q[0] == $past(alloc1) && map_q[1] == $past(alloc0) && map_q[2] == $past(map_q[0])));

    assert_rescue_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rescue_en && rescue_cnt != '0 && drop_en == 2'b00) |=>
            (map_q[0] == $past(head_ent) && vld_q[0] == $past(head_vld)));

    assert_rescue_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rescue_en && rescue_cnt == '0 && drop_en == 2'b00) |=> (vld_q == '0));

    assert_alloc_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_en != 2'b00) |-> (free_mask[alloc0] && free_mask[alloc1] && alloc0 != alloc1));

    assert_err_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_err & ~rd_en) == '0));
endmodule

bind belt_operand_store belt_operand_store_chk #(.NPOS(NPOS), .NPHYS(NPHYS), .NRD(NRD)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .drop_en     (drop_en),
    .rescue_en   (rescue_en),
    .rescue_cnt  (rescue_cnt),
    .rescue_list (rescue_list),
    .rd_en       (rd_en),
    .rd_err      (rd_err),
    .map_q       (map_q),
    .vld_q       (vld_q),
    .free_mask   (free_mask),
    .alloc0      (alloc0),
    .alloc1      (alloc1)
);

// File: tb/tb_belt_operand_store.sv
`timescale 1ns/1ps
// Bench: behavioural belt model compared against every read port each cycle.
module tb_belt_operand_store;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       drop_en = '0;
    logic [1:0][31:0] drop_data = '0;
    logic             rescue_en = 1'b0;
    logic [3:0]       rescue_cnt = '0;
    logic [7:0][2:0]  rescue_list = '0;
    logic [3:0]       rd_en = '0;
    logic [3:0][2:0]  rd_pos = '0;
    logic [3:0][31:0] rd_data;
    logic [3:0]       rd_err;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    logic [31:0] mv [8];
    bit          md [8];

    always #10 clk = ~clk;

    belt_operand_store dut (
        .clk(clk), .rst_n(rst_n), .drop_en(drop_en), .drop_data(drop_data),
        .rescue_en(rescue_en), .rescue_cnt(rescue_cnt), .rescue_list(rescue_list),
        .rd_en(rd_en), .rd_pos(rd_pos), .rd_data(rd_data), .rd_err(rd_err)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            total++; bad++;
            $display("FAIL R10 watchdog actual=%0d cycles expected=finish", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic model_step();
        logic [31:0] tv [8];
        bit          td [8];
        int          c;
        for (int j = 0; j < 8; j++) begin tv[j] = mv[j]; td[j] = md[j]; end
        if (rescue_en) begin
            c = (rescue_cnt > 8) ? 8 : int'(rescue_cnt);
            for (int j = 0; j < 8; j++) begin
                if (j < c) begin
                    tv[j] = mv[rescue_list[c-1-j]];
                    td[j] = md[rescue_list[c-1-j]];
                end else begin
                    tv[j] = '0; td[j] = 1'b0;
                end
            end
        end
        if (drop_en == 2'b11) begin
            for (int j = 7; j >= 2; j--) begin tv[j] = tv[j-2]; td[j] = td[j-2]; end
            tv[1] = drop_data[0]; td[1] = 1'b1;
            tv[0] = drop_data[1]; td[0] = 1'b1;
        end else if (drop_en != 2'b00) begin
            for (int j = 7; j >= 1; j--) begin tv[j] = tv[j-1]; td[j] = td[j-1]; end
            tv[0] = drop_en[0] ? drop_data[0] : drop_data[1]; td[0] = 1'b1;
        end
        for (int j = 0; j < 8; j++) begin mv[j] = tv[j]; md[j] = td[j]; end
    endtask

    // Compare all ports against the pre-update model, then advance one cycle.
    task automatic run_cycle();
        logic [31:0] ed;
        bit          ee;
        #2;
        for (int i = 0; i < 4; i++) begin
            if (!rd_en[i])            begin ed = '0;            ee = 1'b0; end
            else if (md[rd_pos[i]])   begin ed = mv[rd_pos[i]]; ee = 1'b0; end
            else                      begin ed = '0;            ee = 1'b1; end
            total++;
            if (rd_data[i] !== ed || rd_err[i] !== ee) begin
                bad++;
                $display("FAIL %s port %0d pos %0d actual=%h/%b expected=%h/%b",
                         cur_tag, i, rd_pos[i], rd_data[i], rd_err[i], ed, ee);
            end
        end
        model_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        drop_en = '0; rescue_en = 1'b0;
    endtask

    // Two idle cycles reading every position.
    task automatic probe_all();
        idle();
        rd_en = 4'hF;
        for (int h = 0; h < 2; h++) begin
            for (int i = 0; i < 4; i++) rd_pos[i] = 3'(h*4 + i);
            run_cycle();
        end
    endtask

    task automatic drop(input logic [1:0] en, input logic [31:0] a, input logic [31:0] b);
        drop_en = en; drop_data[0] = a; drop_data[1] = b; rescue_en = 1'b0;
        run_cycle();
    endtask

    task automatic rescue(input int cnt, input logic [7:0][2:0] lst, input logic [1:0] en);
        rescue_en = 1'b1; rescue_cnt = 4'(cnt); rescue_list = lst;
        drop_en = en; drop_data[0] = 32'hD0D0_0000 + 32'(cnt); drop_data[1] = 32'hD1D1_0000 + 32'(cnt);
        run_cycle();
        idle();
    endtask

    initial begin
        for (int j = 0; j < 8; j++) begin mv[j] = '0; md[j] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_tag = "R1"; probe_all();

        cur_tag = "R2";
        drop(2'b01, 32'h10, 32'h0);
        drop(2'b10, 32'h0, 32'h11);
        probe_all();

        cur_tag = "R3";
        drop(2'b11, 32'h20, 32'h21);
        probe_all();

        cur_tag = "R4";
        for (int k = 0; k < 4; k++) drop(2'b11, 32'h30 + 32'(2*k), 32'h31 + 32'(2*k));
        probe_all();

        cur_tag = "R5";
        rd_en = 4'hF; rd_pos = {3'd3, 3'd2, 3'd1, 3'd0};
        drop(2'b11, 32'h50, 32'h51);
        probe_all();

        cur_tag = "R6";
        rescue(3, {3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd6, 3'd2, 3'd5}, 2'b00);
        probe_all();

        cur_tag = "R7";
        rescue(4, {3'd0, 3'd0, 3'd0, 3'd0, 3'd1, 3'd0, 3'd0, 3'd2}, 2'b00);
        probe_all();

        cur_tag = "R8";
        rescue(2, {3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd3, 3'd1}, 2'b11);
        probe_all();
        rescue(1, {3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd2}, 2'b10);
        probe_all();

        cur_tag = "R11";
        for (int k = 0; k < 4; k++) drop(2'b11, 32'h70 + 32'(2*k), 32'h71 + 32'(2*k));
        rescue(12, {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7}, 2'b00);
        probe_all();
        rescue(0, '0, 2'b00);
        probe_all();

        cur_tag = "R9";
        drop(2'b01, 32'h90, 32'h0);
        rd_en = 4'b0101; rd_pos = {3'd0, 3'd0, 3'd5, 3'd0};
        run_cycle();

        cur_tag = "R10";
        for (int n = 0; n < 3000; n++) begin
            drop_en      = 2'($urandom);
            drop_data[0] = $urandom;
            drop_data[1] = $urandom;
            rescue_en    = ($urandom % 8) == 0;
            rescue_cnt   = 4'($urandom_range(0, 10));
            for (int k = 0; k < 8; k++) rescue_list[k] = 3'($urandom);
            rd_en        = 4'($urandom);
            for (int i = 0; i < 4; i++) rd_pos[i] = 3'($urandom);
            run_cycle();
        end
        probe_all();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule